// File: doc/BRIEF.md
# Sign-Only Clock Region Deskew Controller

This block is the digital half of a deskew loop for one non-reference region of a resonant clock grid. A binary phase detector placed between this region and the neighbouring region closest to the reference delivers a single bit. The bit says whether this region's clock lags or leads that neighbour. The block brings the bit into its own clock domain through a flip-flop synchronizer. Once per sample period it moves a 7-bit delay-line control code by exactly one unit toward alignment. The loop is first order and uses only the sign of the phase error. When the region is aligned, the code settles into a one-step dither.

The block runs on the region's local clock. It makes its sample period internally by dividing that clock with a clock-enable counter; the default divide ratio is 4. The code is presented in two forms for a load-switched inverter delay line. The upper three bits drive binary-weighted loads. The lower four bits are expanded to a 15-line thermometer bus, which keeps the fine steps monotonic.

Synchronous reset puts the code at mid range. An enable input freezes the loop while deskewing is switched off. A lock flag reports when the decisions have reversed direction eight times in a row.

Top module: `deskew_step_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, until the first sample update, `dly_code` is 64, `coarse_bin` is 4, `fine_therm` is 0 and `locked` is 0.
- R2: The code changes only on sample updates. With the default divide ratio of 4, these fall on the 4th rising edge of `clk` after reset release and on every 4th edge after that.
- R3: At an enabled update, a detector value of `pd_lag`=1 (region lags) lowers `dly_code` by one. A value of 0 (region leads) raises it by one. The code never moves by more than one per update.
- R4: The code saturates. An up decision at 127 leaves it at 127, a down decision at 0 leaves it at 0, and it never wraps.
- R5: While `enable` is 0, updates are skipped. `dly_code`, `locked` and the reversal history stay unchanged whatever `pd_lag` does.
- R6: `coarse_bin` equals `dly_code[6:4]`. Bit i of `fine_therm` is 1 exactly when `dly_code[3:0]` is greater than i (i = 0..14).
- R7: `locked` rises at the enabled update that completes the 8th consecutive direction reversal. The first decision after reset sets no reversal. Any decision in the same direction as the previous one clears the reversal count and drops `locked` at that update.
- R8: `pd_lag` passes through a two-stage synchronizer. A value applied at least two rising edges before an update is the one used. A change made only one edge before an update is not used at that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local region clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 lets the loop step; 0 freezes it |
| pd_lag | input | 1 | Asynchronous detector decision, 1 = this region lags its neighbour |
| dly_code | output | 7 | Delay-line control code |
| coarse_bin | output | 3 | Binary-weighted coarse load select |
| fine_therm | output | 15 | Thermometer fine load select |
| locked | output | 1 | Eight consecutive reversals observed |

## Verification
Saturation and lock detection can act at the same update. This happens when the code is pinned at 0 or 127 and a reversal arrives: the code steps off the limit while the reversal count grows. It also happens when a repeated decision at the limit leaves the code unchanged yet clears the lock. The bench provokes both by driving the code to each limit, then alternating or repeating the decision there. It also runs a long random phase target that makes the loop dither near the ends of the range. A bench model computes the expected code and lock flag for every update, so a saturated step that wrongly counts or clears a reversal shows up as a lock mismatch.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int unsigned CODE_W_DEF   = 7;
    localparam int unsigned FINE_W_DEF   = 4;
    localparam int unsigned DIV_DEF      = 4;
    localparam int unsigned SYNC_DEF     = 2;
    localparam int unsigned LOCK_ALT_DEF = 8;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_req_t;

    function automatic step_dir_e dir_from_pd(input logic lag);
        return lag ? DIR_DN : DIR_UP;
    endfunction

endpackage

// File: rtl/sample_divider.sv
module sample_divider #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/step_counter.sv
module step_counter
    import deskew_pkg::*;
#(
    parameter int unsigned CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  step_req_t         req,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CMAX = '1;
    localparam logic [CODE_W-1:0] CMIN = '0;

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MID;
        end else if (req.valid) begin
            if (req.dir == DIR_UP && code_q != CMAX) begin
                code_q <= code_q + 1'b1;
            end else if (req.dir == DIR_DN && code_q != CMIN) begin
                code_q <= code_q - 1'b1;
            end
        end
    end

    assign code = code_q;
endmodule

// File: rtl/lock_detector.sv
module lock_detector
    import deskew_pkg::*;
#(
    parameter int unsigned LOCK_ALT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  step_req_t req,
    output logic      locked
);
    localparam int unsigned ALT_W = $clog2(LOCK_ALT + 1);
    localparam logic [ALT_W-1:0] LIMIT = ALT_W'(LOCK_ALT);

    logic [ALT_W-1:0] alt_q;
    logic             seen_q;
    step_dir_e        prev_q;
    logic             lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q  <= '0;
            seen_q <= 1'b0;
            prev_q <= DIR_UP;
            lock_q <= 1'b0;
        end else if (req.valid) begin
            seen_q <= 1'b1;
            prev_q <= req.dir;
            if (seen_q && req.dir != prev_q) begin
                if (alt_q != LIMIT) alt_q <= alt_q + 1'b1;
                lock_q <= (alt_q >= LIMIT - 1'b1);
            end else begin
                alt_q  <= '0;
                lock_q <= 1'b0;
            end
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/code_splitter.sv
module code_splitter #(
    parameter int unsigned CODE_W = 7,
    parameter int unsigned FINE_W = 4
) (
    input  logic [CODE_W-1:0]          code,
    output logic [CODE_W-FINE_W-1:0]   bin_out,
    output logic [(1<<FINE_W)-2:0]     therm_out
);
    localparam int unsigned THERM_W = (1 << FINE_W) - 1;

    logic [FINE_W-1:0] fine;
    assign fine    = code[FINE_W-1:0];
    assign bin_out = code[CODE_W-1:FINE_W];

    generate
        for (genvar i = 0; i < THERM_W; i++) begin : g_therm
            assign therm_out[i] = (fine > FINE_W'(i));
        end
    endgenerate
endmodule

// File: rtl/deskew_step_ctrl.sv
module deskew_step_ctrl
    import deskew_pkg::*;
#(
    parameter int unsigned CODE_W   = CODE_W_DEF,
    parameter int unsigned FINE_W   = FINE_W_DEF,
    parameter int unsigned DIV      = DIV_DEF,
    parameter int unsigned SYNC     = SYNC_DEF,
    parameter int unsigned LOCK_ALT = LOCK_ALT_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic                     pd_lag,
    output logic [CODE_W-1:0]        dly_code,
    output logic [CODE_W-FINE_W-1:0] coarse_bin,
    output logic [(1<<FINE_W)-2:0]   fine_therm,
    output logic                     locked
);
    logic      tick;
    logic      lag_sync;
    step_req_t req;

    sample_divider #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    bit_sync #(.STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pd_lag),
        .q   (lag_sync)
    );

    always_comb begin
        req.valid = tick & enable;
        req.dir   = dir_from_pd(lag_sync);
    end

    step_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .code (dly_code)
    );

    lock_detector #(.LOCK_ALT(LOCK_ALT)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .locked (locked)
    );

    code_splitter #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_split (
        .code      (dly_code),
        .bin_out   (coarse_bin),
        .therm_out (fine_therm)
    );
endmodule

// File: rtl/deskew_step_ctrl_chk.sv
module deskew_step_ctrl_chk #(
    parameter int unsigned CODE_W = 7,
    parameter int unsigned FINE_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     enable,
    input logic [CODE_W-1:0]        dly_code,
    input logic [CODE_W-FINE_W-1:0] coarse_bin,
    input logic [(1<<FINE_W)-2:0]   fine_therm,
    input logic                     locked
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CMAX = '1;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    // R1
    reset_value_chk: assert property (@(posedge clk)
        $past(rst) |-> (dly_code == MID && !locked));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) |-> (dly_code == $past(dly_code) ||
                             dly_code == $past(dly_code) + 1'b1 ||
                             dly_code == $past(dly_code) - 1'b1));

    // R4
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $past(dly_code) == CMAX) |-> dly_code != '0);

    // R4
    no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $past(dly_code) == '0) |-> dly_code != CMAX);

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && !$past(enable)) |-> ($stable(dly_code) && $stable(locked)));

    // R2
    spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(dly_code) != $past(dly_code, 2)) |-> $stable(dly_code));

    // R6
    therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(fine_therm) == int'(dly_code[FINE_W-1:0]) &&
         ((fine_therm & (fine_therm + 1'b1)) == '0) &&
         coarse_bin == dly_code[CODE_W-1:FINE_W]));

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && $rose(locked)) |-> $past(enable));
endmodule

bind deskew_step_ctrl deskew_step_ctrl_chk #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .dly_code   (dly_code),
    .coarse_bin (coarse_bin),
    .fine_therm (fine_therm),
    .locked     (locked)
);

// File: tb/sim_deskew_step_ctrl.sv
`timescale 1ns/1ps
module sim_deskew_step_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        pd_lag = 1'b0;
    logic [6:0]  dly_code;
    logic [2:0]  coarse_bin;
    logic [14:0] fine_therm;
    logic        locked;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    int m_code;
    int m_alt;
    bit m_seen;
    bit m_prev;
    bit m_lock;

    always #2.5 clk = ~clk;

    deskew_step_ctrl u0 (
        .clk(clk), .rst(rst), .enable(enable), .pd_lag(pd_lag),
        .dly_code(dly_code), .coarse_bin(coarse_bin),
        .fine_therm(fine_therm), .locked(locked)
    );

    function automatic int therm_exp(input int f);
        logic [15:0] t;
        t = (16'd1 << f) - 16'd1;
        return int'(t[14:0]);
    endfunction

    task automatic cmp(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_code = 64; m_alt = 0; m_seen = 0; m_prev = 0; m_lock = 0;
    endtask

    task automatic model_step(input bit lag, input bit en);
        if (!en) return;
        if (lag) begin if (m_code > 0) m_code--; end
        else     begin if (m_code < 127) m_code++; end
        if (m_seen && lag != m_prev) begin
            if (m_alt < 8) m_alt++;
            m_lock = (m_alt >= 8);
        end else begin
            m_alt = 0; m_lock = 0;
        end
        m_seen = 1; m_prev = lag;
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " R3 code"}, int'(dly_code), m_code);
        cmp("R6 coarse", int'(coarse_bin), m_code / 16);
        cmp("R6 therm", int'(fine_therm), therm_exp(m_code % 16));
        cmp("R7 locked", int'(locked), int'(m_lock));
    endtask

    // called at a negedge; ends at the negedge after the update
    task automatic period(input bit lag, input bit en, input string tag);
        pd_lag = lag; enable = en;
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        model_step(lag, en);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int target;
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 during reset
        cmp("R1 code in reset", int'(dly_code), 64);
        cmp("R1 coarse in reset", int'(coarse_bin), 4);
        cmp("R1 therm in reset", int'(fine_therm), 0);
        cmp("R1 locked in reset", int'(locked), 0);
        rst = 1'b0; enable = 1'b1; pd_lag = 1'b0;
        // R2: no change before 4th edge
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R2 no update before tick", int'(dly_code), 64);
        cmp("R1 locked after release", int'(locked), 0);
        @(posedge clk);
        @(negedge clk);
        model_step(1'b0, 1'b1);
        cmp("R2 update on 4th edge", int'(dly_code), 65);

        // R4 upward saturation
        for (int i = 0; i < 70; i++) period(1'b0, 1'b1, "R4 up");
        cmp("R4 held at top", int'(dly_code), 127);
        // reversal at the top while saturated: lock count interplay
        period(1'b1, 1'b1, "R4 off top");
        period(1'b0, 1'b1, "R4 back top");
        period(1'b0, 1'b1, "R4 repeat top");
        // R4 downward saturation
        for (int i = 0; i < 140; i++) period(1'b1, 1'b1, "R4 down");
        cmp("R4 held at bottom", int'(dly_code), 0);

        // R8: late change is not used
        pd_lag = 1'b0; enable = 1'b1;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        pd_lag = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_step(1'b0, 1'b1);
        cmp("R8 late change ignored", int'(dly_code), 1);

        // R5 freeze
        for (int i = 0; i < 12; i++) period(i[0], 1'b0, "R5 frozen");
        cmp("R5 code frozen", int'(dly_code), m_code);

        // R7 lock by alternation
        for (int i = 0; i < 12; i++) begin
            period(i[0], 1'b1, "R7 alt");
            if (i == 7) cmp("R7 not yet locked", int'(locked), 0);
            if (i == 8) cmp("R7 locked at 8th reversal", int'(locked), 1);
        end
        period(1'b1, 1'b1, "R7 same dir");
        cmp("R7 cleared by repeat", int'(locked), 0);

        // random phase target with dither, random enable
        target = 64;
        for (int i = 0; i < 2000; i++) begin
            bit lag;
            bit en;
            if (($urandom % 200) == 0) target = $urandom % 128;
            en  = (($urandom % 10) != 0);
            lag = (($urandom % 16) == 0) ? bit'($urandom % 2) : (m_code > target);
            period(lag, en, "R3 random");
        end
        // drive to extremes with dither there
        target = 127;
        for (int i = 0; i < 100; i++) period(m_code >= target, 1'b1, "R4 dither top");
        target = 0;
        for (int i = 0; i < 160; i++) period(m_code > target, 1'b1, "R4 dither bottom");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule